// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Selectable Latency

This block is an on-chip memory with one write port and one read port that share a single clock. It is meant to take the place of a memory with an asynchronous read inside a datapath that is already built from registers. The write address, write data, write enable, read address and read enable are always captured on the active clock edge. The write strobe is made inside the block, so there is no external write pulse to shape.

Two elaboration parameters set the timing. `OUT_MODE` selects flow-through output, where read data comes straight from the array's read register, or pipelined output, which adds one more register. `CLK_EDGE` selects whether the array is clocked on the rising edge or on the inverted clock. With the inverted clock and flow-through output, a rising-edge register placed after the RAM captures the word for an address that was applied in the same cycle, as an asynchronous-read memory would give it.

Top module: `sdp_ram_sync`

## Requirements
- R1: Every active edge at which `wr_en` is high stores that cycle's `wr_data` at that cycle's `wr_addr`. `wr_en` may stay high for any number of cycles, and the address may change on every one of them.
- R2: An active edge at which `wr_en` is low leaves every stored word unchanged, whatever `wr_addr` and `wr_data` carry.
- R3: Flow-through with rising-edge clocking: the word for `rd_addr` applied in cycle n appears on `rd_data` after the rising edge that ends cycle n, and holds through cycle n+1.
- R4: Pipelined with rising-edge clocking: the word for `rd_addr` applied in cycle n appears on `rd_data` during cycle n+2.
- R5: Flow-through with inverted clocking: the word for `rd_addr` applied in cycle n appears on `rd_data` after the falling edge inside cycle n, before the rising edge that ends it.
- R6: Pipelined with inverted clocking: the word for `rd_addr` applied in cycle n appears on `rd_data` after the falling edge inside cycle n+1.
- R7: When a read and a write hit the same address on the same active edge, the read returns the word that was stored before that write. This holds in both output modes.
- R8: In pipelined mode, `rd_en` is captured together with `rd_addr`. If it was low, the output register keeps its previous value and does not load the new word. In flow-through mode, `rd_en` has no effect on `rd_data`.
- R9: In pipelined mode, the output register goes to all zeros as soon as `rst_n` goes low. It stays at zero until the first enabled read reaches it. The array contents are not defined by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. The array uses either this clock or its inverse. |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised to the array clock. |
| wr_en | input | 1 | Write enable, sampled on the active edge. |
| wr_addr | input | ADDR_W | Write address. |
| wr_data | input | DATA_W | Write data. |
| rd_addr | input | ADDR_W | Read address. |
| rd_en | input | 1 | Read enable for the output register. Used in pipelined mode only. |
| rd_data | output | DATA_W | Read data. |

## Verification
The bench drives four instances in parallel, one for each combination of output mode and clock edge, with the same stimulus.

- **Burst write:** a write burst with `wr_en` held high and a new address every cycle, while each cycle reads the word written one cycle earlier. An off-by-one in write or read latency shows up as a mismatch here.
- **Collision pass:** every cycle reads and writes the same address. This tells read-before-write apart from write-through.
- **Enable pattern and no-write pass:** a read sweep with `rd_en` dropping every third cycle separates the hold behaviour of the pipelined register from the flow-through path. A pass with `wr_en` low and changing addresses and data shows that no write leaks through.
- **Mixed traffic:** a long stretch driven by an LFSR mixes all of the above.
- **Reset:** a final asynchronous reset confirms that the output register clears.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } clk_edge_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/sdp_clk_sel.sv
module sdp_clk_sel
  import sdp_pkg::*;
#(
  parameter clk_edge_e CLK_EDGE = EDGE_RISE
) (
  input  logic clk_i,
  output logic clk_o
);

  generate
    if (CLK_EDGE == EDGE_FALL) begin : g_inv
      assign clk_o = ~clk_i;
    end else begin : g_pass
      assign clk_o = clk_i;
    end
  endgenerate

endmodule

// File: rtl/sdp_rst_sync.sv
module sdp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[LAST];

endmodule

// File: rtl/sdp_array.sv
module sdp_array #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              rd_en_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word_q;
  logic              rd_en_q;
  logic              rd_en_d;

  // Storage write and read capture share one edge; the read sees the old word.
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
    rd_word_q <= mem[rd_addr_i];
  end

  always_comb begin
    rd_en_d = rd_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q <= 1'b0;
    end else begin
      rd_en_q <= rd_en_d;
    end
  end

  assign rd_word_o = rd_word_q;
  assign rd_en_o   = rd_en_q;

  // R1: a captured write is present in the array one edge later
  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem[$past(wr_addr_i)] == $past(wr_data_i)));

  // R7: on an address collision the read register does not take the new word
  a_r7_old_on_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == rd_addr_i) && (mem[wr_addr_i] != wr_data_i))
      |=> (rd_word_q != $past(wr_data_i)));

endmodule

// File: rtl/sdp_out_reg.sv
module sdp_out_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_q;
  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) begin
      q_d = d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R8: a disabled cycle keeps the held word
  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_q));

  // R9: the first cycle out of reset still shows zero
  a_r9_clear_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (q_q == '0));

endmodule

// File: rtl/sdp_ram_sync.sv
module sdp_ram_sync
  import sdp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter out_mode_e   OUT_MODE = OUT_PIPE,
  parameter clk_edge_e   CLK_EDGE = EDGE_RISE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);

  logic              arr_clk;
  logic              arr_rst_n;
  logic [DATA_W-1:0] rd_word;
  logic              rd_en_q;

  sdp_clk_sel #(
    .CLK_EDGE (CLK_EDGE)
  ) u_clk_sel (
    .clk_i (clk),
    .clk_o (arr_clk)
  );

  sdp_rst_sync #(
    .STAGES (RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (arr_clk),
    .rst_ni (rst_n),
    .rst_no (arr_rst_n)
  );

  sdp_array #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk_i     (arr_clk),
    .rst_ni    (arr_rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_en_i   (rd_en),
    .rd_word_o (rd_word),
    .rd_en_o   (rd_en_q)
  );

  generate
    if (OUT_MODE == OUT_PIPE) begin : g_pipe
      sdp_out_reg #(
        .DATA_W (DATA_W)
      ) u_out_reg (
        .clk_i  (arr_clk),
        .rst_ni (arr_rst_n),
        .en_i   (rd_en_q),
        .d_i    (rd_word),
        .q_o    (rd_data)
      );
    end else begin : g_flow
      assign rd_data = rd_word;
    end
  endgenerate

endmodule

// File: tb/tb_sdp_ram_sync.sv
module tb_sdp_ram_sync;
  import sdp_pkg::*;

  localparam int CLK_T = 10;
  localparam int DW    = 16;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int HMAX  = 1024;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] q_rp, q_rf, q_ip, q_if;

  int total;
  int bad;
  int n;
  bit done;

  logic [DW-1:0] mm [DEPTH];
  bit            mk [DEPTH];
  logic [DW-1:0] rv_h [HMAX];
  bit            kv_h [HMAX];
  bit            en_h [HMAX];
  logic [DW-1:0] pi_v, pr_v;
  bit            pi_k, pr_k;
  logic [15:0]   lf;

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  sdp_ram_sync #(.DATA_W(DW), .ADDR_W(AW), .OUT_MODE(OUT_PIPE), .CLK_EDGE(EDGE_RISE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(q_rp));

  sdp_ram_sync #(.DATA_W(DW), .ADDR_W(AW), .OUT_MODE(OUT_FLOW), .CLK_EDGE(EDGE_RISE)) dut_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(q_rf));

  sdp_ram_sync #(.DATA_W(DW), .ADDR_W(AW), .OUT_MODE(OUT_PIPE), .CLK_EDGE(EDGE_FALL)) dut_ip (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(q_ip));

  sdp_ram_sync #(.DATA_W(DW), .ADDR_W(AW), .OUT_MODE(OUT_FLOW), .CLK_EDGE(EDGE_FALL)) dut_if (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(q_if));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, n, act, exp);
    end
  endtask

  // One cycle: drive after the rising edge, sample after the falling edge.
  task automatic step(input bit we, input int wa, input logic [DW-1:0] wd,
                      input int ra, input bit re, input string ptag);
    @(posedge clk);
    #2;
    wr_en   = we;
    wr_addr = wa[AW-1:0];
    wr_data = wd;
    rd_addr = ra[AW-1:0];
    rd_en   = re;
    rv_h[n] = mm[ra];
    kv_h[n] = mk[ra];
    en_h[n] = re;
    if (we) begin
      mm[wa] = wd;
      mk[wa] = 1'b1;
    end
    #6;
    if (kv_h[n]) chk({"R5 ", ptag}, q_if, rv_h[n]);
    if (n >= 1 && kv_h[n-1]) chk({"R3 ", ptag}, q_rf, rv_h[n-1]);
    if (n >= 1 && en_h[n-1]) begin
      pi_v = rv_h[n-1];
      pi_k = kv_h[n-1];
    end
    if (pi_k) chk({"R6 ", ptag}, q_ip, pi_v);
    if (n >= 2 && en_h[n-2]) begin
      pr_v = rv_h[n-2];
      pr_k = kv_h[n-2];
    end
    if (pr_k) chk({"R4 ", ptag}, q_rp, pr_v);
    n++;
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_T * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 run did not complete actual=hung expected=done");
      report();
    end
  end

  initial begin
    total = 0; bad = 0; n = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    pi_v = '0; pi_k = 1'b1; pr_v = '0; pr_k = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      mm[i] = '0;
      mk[i] = 1'b0;
    end
    for (int i = 0; i < 4; i++) step(1'b0, 0, '0, 0, 1'b0, "R9 reset");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, 0, '0, 0, 1'b0, "R9 idle");
    // R1: burst fill, new address every cycle, read of the previous word
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, i, DW'(i * 37 + 16'h5A00), (i + DEPTH - 1) % DEPTH, 1'b1, "R1 burst");
    // R7: read and write the same address on every edge
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, i, DW'(16'hC300 ^ (i * 16'h0101)), i, 1'b1, "R7 collide");
    // R8: read sweep with enable dropping every third cycle
    for (int i = 0; i < 48; i++)
      step(1'b0, i % DEPTH, 16'hFFFF, (i * 7) % DEPTH, (i % 3) != 0, "R8 enable");
    // R2: write enable low with live address and data
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, i, DW'(16'hDEAD ^ i), (i + DEPTH - 1) % DEPTH, 1'b1, "R2 nowrite");
    // R1: mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], int'(lf[5:1]), lf ^ 16'h3C3C, int'(lf[10:6]), lf[11] | lf[12], "R1 mixed");
    end
    step(1'b0, 0, '0, 3, 1'b1, "R4 drain");
    step(1'b0, 0, '0, 3, 1'b1, "R4 drain");
    step(1'b0, 0, '0, 3, 1'b0, "R4 drain");
    // R9: asynchronous reset clears the output registers at once
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #6;
    chk("R9 async clear rise", q_rp, '0);
    chk("R9 async clear fall", q_ip, '0);
    done = 1'b1;
    report();
  end

endmodule